// File: doc/BRIEF.md
# 6x6 Carry-Save Output Multiplier

This block multiplies two 6-bit unsigned operands. It does not resolve the result into one binary word. It returns two words whose weighted sum is the product, so that a larger multiplier built from several of these tiles can defer carry propagation to one shared final adder. The first word is 11 bits wide at weight 1. The second word is 6 bits wide at weight 32, which makes it the bits 10 down to 5 of a 17-bit carry-save pair. Its five lower bits are always zero, so they are not brought out as ports.

Partial products are plain AND terms, with no operand recoding. The five lower operand rows (a[0] to a[4]) are reduced column by column. A flat array of population counters counts the bits of each column, and the weighted column counts are merged into the first word. The top operand row (a[5]) needs no reduction: it passes through as single bits into the second word, because its weight 32 matches the second word's offset exactly. The datapath is purely combinational and has no clock or state.

The operand widths are parameters. The second word's offset follows the first operand's width, and the first word's width follows from both widths.

Top module: `csmul_array`

## Requirements
- R1: For every pair of operands, `p + q*32` equals `a*b`. Here q is read as the 6-bit value on port `q`, so its LSB carries weight 32.
- R2: `q` equals `b` when `a[5]` is 1, and `q` is zero when `a[5]` is 0.
- R3: `p` equals `a[4:0] * b`, the sum of the five lower operand rows.
- R4: When either operand is zero, both `p` and `q` are zero.
- R5: `p` never exceeds 1953 (31*63), so it fits its 11 bits with no carry out. At `a = b = 63`, `p` is 1953 and `q` is 63.
- R6: The outputs are a combinational function of the current operands. A new operand pair shows its result without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 6 | Multiplicand, unsigned |
| b | input | 6 | Multiplier, unsigned |
| p | output | 11 | First carry-save word, weight 1 |
| q | output | 6 | Second carry-save word, declared [10:5], weight 32 |

## Verification
The bench builds the block with its default widths of 6 and 6. At these widths the whole operand space is 4096 pairs, so an exhaustive sweep fits easily in the run, and every split between the two words is checked. This includes the pairs with a[5] set, where the top row moves into the second word. Seeded random pairs and directed corners are added on top of the sweep: zero operands, all-ones operands, and a[4:0] at its maximum. These pin the largest value of the first word and the sharing of the result between the two words.

// File: rtl/csmul_pkg.sv
package csmul_pkg;

    localparam int unsigned OPA_W = 6;
    localparam int unsigned OPB_W = 6;

    // Number of partial-product bits of the lower rows that land in a column.
    function automatic int unsigned col_height(input int unsigned col,
                                               input int unsigned rows,
                                               input int unsigned cols);
        int unsigned h;
        h = 0;
        for (int unsigned r = 0; r < rows; r++) begin
            if (col >= r && (col - r) < cols) h++;
        end
        return h;
    endfunction

    // Largest value the first word can take: (2^(na-1)-1) * (2^nb-1).
    function automatic longint unsigned p_ceiling(input int unsigned na,
                                                  input int unsigned nb);
        return ((64'd1 << (na - 1)) - 64'd1) * ((64'd1 << nb) - 64'd1);
    endfunction

endpackage

// File: rtl/csmul_pp_gen.sv
module csmul_pp_gen #(
    parameter int unsigned NA = 6,
    parameter int unsigned NB = 6
) (
    input  logic [NA-1:0]         a,
    input  logic [NB-1:0]         b,
    output logic [NA-1:0][NB-1:0] pp
);

    // Non-recoded AND array: row r, bit j has weight r + j.
    for (genvar r = 0; r < NA; r++) begin : g_row
        for (genvar j = 0; j < NB; j++) begin : g_bit
            assign pp[r][j] = a[r] & b[j];
        end
    end

endmodule

// File: rtl/csmul_col_count.sv
module csmul_col_count #(
    parameter int unsigned H  = 5,
    parameter int unsigned CW = 3
) (
    input  logic [H-1:0]  bits,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(H); i++) begin
            cnt = cnt + CW'(bits[i]);
        end
    end

endmodule

// File: rtl/csmul_word_merge.sv
module csmul_word_merge
    import csmul_pkg::*;
#(
    parameter int unsigned NA = 6,
    parameter int unsigned NB = 6,
    localparam int unsigned NCOL = (NA - 1) + NB - 1,
    localparam int unsigned CW   = $clog2(NA),
    localparam int unsigned PW   = NA + NB - 1
) (
    input  logic [NCOL-1:0][CW-1:0] col_cnt,
    input  logic [NB-1:0]           top_row,
    output logic [PW-1:0]           p,
    output logic [NB-1:0]           q
);

    localparam longint unsigned PMAX = p_ceiling(NA, NB);

    // Weighted merge of the column counts into the first word.
    always_comb begin
        p = '0;
        for (int k = 0; k < int'(NCOL); k++) begin
            p = p + (PW'(col_cnt[k]) << k);
        end
    end

    // The top row has weight NA-1, matching the second word's offset.
    assign q = top_row;

    always_comb begin
        p_no_overflow_r5: assert (64'(p) <= PMAX)
            else $error("first word %0d above ceiling %0d", p, PMAX);
    end

endmodule

// File: rtl/csmul_array.sv
module csmul_array
    import csmul_pkg::*;
#(
    parameter int unsigned NA = OPA_W,
    parameter int unsigned NB = OPB_W,
    localparam int unsigned PW = NA + NB - 1,
    localparam int unsigned QO = NA - 1
) (
    input  logic [NA-1:0]   a,
    input  logic [NB-1:0]   b,
    output logic [PW-1:0]   p,
    output logic [PW-1:QO]  q
);

    localparam int unsigned ROWS_LO = NA - 1;
    localparam int unsigned NCOL    = ROWS_LO + NB - 1;
    localparam int unsigned CW      = $clog2(NA);
    localparam int unsigned XW      = PW + 1;

    logic [NA-1:0][NB-1:0]       pp;
    logic [NCOL-1:0][ROWS_LO-1:0] col_bits;
    logic [NCOL-1:0][CW-1:0]      col_cnt;
    logic [NB-1:0]               q_word;

    csmul_pp_gen #(.NA(NA), .NB(NB)) u_pp (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    // Gather each column of the lower rows; absent positions are tied low.
    for (genvar k = 0; k < NCOL; k++) begin : g_col
        for (genvar r = 0; r < ROWS_LO; r++) begin : g_slot
            if ((k >= r) && ((k - r) < NB)) begin : g_live
                assign col_bits[k][r] = pp[r][k-r];
            end else begin : g_dead
                assign col_bits[k][r] = 1'b0;
            end
        end
        csmul_col_count #(.H(ROWS_LO), .CW(CW)) u_cnt (
            .bits (col_bits[k]),
            .cnt  (col_cnt[k])
        );
    end

    csmul_word_merge #(.NA(NA), .NB(NB)) u_merge (
        .col_cnt (col_cnt),
        .top_row (pp[NA-1]),
        .p       (p),
        .q       (q_word)
    );

    assign q = q_word;

    always_comb begin
        p_split_r1: assert ((XW'(p) + (XW'(q) << QO)) == (XW'(a) * XW'(b)))
            else $error("carry-save pair does not sum to product");
        if (!a[NA-1]) begin
            p_qzero_r2: assert (q == '0)
                else $error("second word nonzero with top operand bit clear");
        end
        if ((a == '0) || (b == '0)) begin
            p_zero_r4: assert ((p == '0) && (q == '0))
                else $error("zero operand gave nonzero result");
        end
    end

endmodule

// File: tb/tb_csmul_array.sv
module tb_csmul_array;

    localparam int NA = 6;
    localparam int NB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NA-1:0] a = '0;
    logic [NB-1:0] b = '0;
    logic [10:0]   p;
    logic [10:5]   q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    csmul_array dut (.a(a), .b(b), .p(p), .q(q));

    function automatic int exp_q(input int x, input int y);
        return (x >= 32) ? y : 0;
    endfunction

    function automatic int exp_p(input int x, input int y);
        return (x % 32) * y;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
        end
    endtask

    // Drive at negedge, sample shortly after: the block is combinational (R6).
    task automatic apply(input int x, input int y);
        @(negedge clk);
        a = NA'(x);
        b = NB'(y);
        #1;
        chk("R1", int'(p) + int'(q) * 32, x * y);
        chk("R2", int'(q), exp_q(x, y));
        chk("R3", int'(p), exp_p(x, y));
        if (x == 0 || y == 0) chk("R4", int'(p) + int'(q), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        chk("R4", int'(p), 0);              // idle operands zero
        chk("R4", int'(q), 0);
        apply(63, 63);
        chk("R5", int'(p), 1953);
        chk("R5", int'(q), 63);
        apply(31, 63);
        chk("R5", int'(p), 1953);
        apply(32, 1);
        chk("R2", int'(q), 1);
        apply(0, 63);
        apply(63, 0);
        // R6: an operand change without any clock edge between
        a = 6'd5; b = 6'd7; #1;
        chk("R6", int'(p), 35);
        a = 6'd40; #1;
        chk("R6", int'(p) + int'(q) * 32, 280);
        void'($urandom(32'd1234));
        for (int n = 0; n < 500; n++) apply(int'($urandom % 64), int'($urandom % 64));
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) apply(x, y);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule